// File: doc/BRIEF.md
# Bus Stall Timeout Watchdog

This block guards a two-wire serial bus controller against a transfer that stalls forever. While the bus engine reports that it is waiting on the bus (for example, on a target holding the clock low), the watchdog counts in steps of a power-of-two number of core clocks. When the number of steps in one uninterrupted stall reaches a programmed limit, it emits a one-cycle timeout pulse for the interrupt logic and sets a sticky timeout flag that software clears with a write-one strobe.

Software programs a 16-bit control word, with the enable in the top bit and the 15-bit limit below it, and a separate 4-bit step-size select n. A step then lasts 2^n core clocks. Turning the limit into time, and raising n when the limit would not fit in 15 bits, is left to software. Clearing the enable while keeping the limit stops the count, and setting it again restarts the count from zero.

Top module: `i2c_stall_watchdog`

## Requirements
- R1: After synchronous reset, `tmo_flag` and `tmo_pulse` are 0.
- R2: No step is counted and `tmo_pulse` stays 0 while `wd_ctrl[15]` (enable) is 0 or `bus_wait` is 0.
- R3: With `step_sel` = n (0 to 15), one step is counted every 2^n core clocks of an active stall. The first step falls on the 2^n-th rising edge of the stall.
- R4: With `wd_ctrl[14:0]` = L, the timeout fires when the step count of one stall reaches max(L,1). If the stall becomes active before rising edge e0, `tmo_pulse` is 1 for exactly the cycle after edge e0 + max(L,1)·2^n − 1.
- R5: A limit of 0 with the enable set fires on the first step of a stall.
- R6: A stall fires at most once. After firing, the count holds and `tmo_pulse` stays 0 until the stall ends or the enable drops.
- R7: When `bus_wait` drops for one cycle, the step count and the step prescaler both return to zero.
- R8: Clearing `wd_ctrl[15]` while keeping `wd_ctrl[14:0]`, then setting it again, restarts the count from zero.
- R9: `tmo_flag` rises in the same cycle as `tmo_pulse` and stays 1 until a cycle with `tmo_clr` = 1. In the cycle after that, it reads 0.
- R10: When `tmo_clr` and a timeout fall on the same edge, the clear wins: `tmo_pulse` is 1 and `tmo_flag` is 0.
- R11: The limit is compared as count ≥ limit. If the limit is lowered below the count reached so far in a stall, the timeout fires on the next step.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock |
| rst | input | 1 | Synchronous active-high reset |
| wd_ctrl | input | 16 | Bit 15 enable, bits 14:0 step limit |
| step_sel | input | 4 | log2 of core clocks per step |
| bus_wait | input | 1 | Bus engine is stalled waiting on the bus |
| tmo_clr | input | 1 | Write-one strobe clearing the sticky flag |
| tmo_flag | output | 1 | Sticky timeout status |
| tmo_pulse | output | 1 | One-cycle timeout event for interrupt logic |

## Verification
The bench checks the exact firing edge at the smallest and largest step sizes, including a limit of zero. An off-by-one in the prescaler or the compare would move the pulse by a step. A short dip in the wait qualifier must restart the timing, and a design that kept its count across the dip would fire early. The same applies to an enable drop that preserves the limit. The bench also lowers the limit below the running count, where an equality compare would never fire. It places a clear on the same edge as a timeout, where the wrong priority would leave the flag set. Finally, it holds a stall long after firing, where a free-running counter would pulse again.

// File: rtl/stall_wd_pkg.sv
package stall_wd_pkg;

  typedef enum logic [0:0] {
    WD_COUNTING = 1'b0,
    WD_EXPIRED  = 1'b1
  } wd_state_e;

  typedef struct packed {
    logic tick;
    logic hit;
  } wd_evt_t;

endpackage

// File: rtl/wd_tick_gen.sv
module wd_tick_gen #(
  parameter int SEL_W = 4,
  parameter int PRE_W = 15
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             active,
  input  logic [SEL_W-1:0] sel,
  output logic             tick
);
  logic [PRE_W-1:0] pre_q;
  logic [PRE_W-1:0] wrap_mask;

  // wrap point 2^sel - 1, one bit per possible prescale stage
  for (genvar gi = 0; gi < PRE_W; gi++) begin : g_mask
    assign wrap_mask[gi] = (sel > SEL_W'(gi));
  end

  // >= keeps a mid-stall reduction of sel from running to full wrap
  assign tick = active && (pre_q >= wrap_mask);

  always_ff @(posedge clk) begin
    if (rst || !active) begin
      pre_q <= '0;
    end else if (tick) begin
      pre_q <= '0;
    end else begin
      pre_q <= pre_q + PRE_W'(1);
    end
  end
endmodule

// File: rtl/wd_stall_counter.sv
module wd_stall_counter
  import stall_wd_pkg::*;
#(
  parameter int LIM_W = 15
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             active,
  input  logic             tick,
  input  logic [LIM_W-1:0] limit,
  output logic             hit
);
  localparam int CW = LIM_W + 1;

  wd_state_e        state_q;
  logic [LIM_W-1:0] cnt_q;
  logic [CW-1:0]    cnt_inc;

  assign cnt_inc = {1'b0, cnt_q} + CW'(1);
  assign hit = active && tick && (state_q == WD_COUNTING) &&
               (cnt_inc >= {1'b0, limit});

  always_ff @(posedge clk) begin
    if (rst || !active) begin
      cnt_q   <= '0;
      state_q <= WD_COUNTING;
    end else if (tick && state_q == WD_COUNTING) begin
      cnt_q <= cnt_inc[LIM_W-1:0];
      if (hit) begin
        state_q <= WD_EXPIRED;
      end
    end
  end
endmodule

// File: rtl/wd_status_flag.sv
module wd_status_flag (
  input  logic clk,
  input  logic rst,
  input  logic hit,
  input  logic clr,
  output logic flag,
  output logic pulse
);
  always_ff @(posedge clk) begin
    if (rst) begin
      flag  <= 1'b0;
      pulse <= 1'b0;
    end else begin
      pulse <= hit;
      if (clr) begin
        flag <= 1'b0;
      end else if (hit) begin
        flag <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/i2c_stall_watchdog.sv
module i2c_stall_watchdog
  import stall_wd_pkg::*;
#(
  parameter int LIMIT_W = 15,
  parameter int PSEL_W  = 4
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [LIMIT_W:0]    wd_ctrl,
  input  logic [PSEL_W-1:0]   step_sel,
  input  logic                bus_wait,
  input  logic                tmo_clr,
  output logic                tmo_flag,
  output logic                tmo_pulse
);
  localparam int PRE_W  = (1 << PSEL_W) - 1;
  localparam int EN_BIT = LIMIT_W;

  wd_evt_t          evt;
  logic             active;
  logic [LIMIT_W-1:0] limit;

  assign limit  = wd_ctrl[LIMIT_W-1:0];
  assign active = wd_ctrl[EN_BIT] && bus_wait;

  wd_tick_gen #(.SEL_W(PSEL_W), .PRE_W(PRE_W)) u_tick (
    .clk(clk), .rst(rst), .active(active), .sel(step_sel), .tick(evt.tick)
  );

  wd_stall_counter #(.LIM_W(LIMIT_W)) u_cnt (
    .clk(clk), .rst(rst), .active(active), .tick(evt.tick),
    .limit(limit), .hit(evt.hit)
  );

  wd_status_flag u_flag (
    .clk(clk), .rst(rst), .hit(evt.hit), .clr(tmo_clr),
    .flag(tmo_flag), .pulse(tmo_pulse)
  );
endmodule

// File: rtl/wd_stall_checker.sv
module wd_stall_checker #(
  parameter int LIMIT_W = 15
) (
  input logic             clk,
  input logic             rst,
  input logic [LIMIT_W:0] wd_ctrl,
  input logic             bus_wait,
  input logic             tmo_clr,
  input logic             tmo_flag,
  input logic             tmo_pulse
);
  // R2
  idle_no_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    (!wd_ctrl[LIMIT_W] || !bus_wait) |=> !tmo_pulse);

  // R6
  single_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    tmo_pulse |=> !tmo_pulse);

  // R9
  flag_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    (tmo_flag && !tmo_clr) |=> tmo_flag);

  // R9
  flag_clear_chk: assert property (@(posedge clk) disable iff (rst)
    tmo_clr |=> !tmo_flag);

  // R9
  flag_cause_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(tmo_flag) |-> tmo_pulse);

  // R10
  pulse_sets_flag_chk: assert property (@(posedge clk) disable iff (rst)
    (tmo_pulse && !$past(tmo_clr)) |-> tmo_flag);
endmodule

bind i2c_stall_watchdog wd_stall_checker #(.LIMIT_W(LIMIT_W)) u_wd_chk (
  .clk(clk), .rst(rst), .wd_ctrl(wd_ctrl), .bus_wait(bus_wait),
  .tmo_clr(tmo_clr), .tmo_flag(tmo_flag), .tmo_pulse(tmo_pulse)
);

// File: tb/i2c_stall_watchdog_bench.sv
module i2c_stall_watchdog_bench;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 150000;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        en  = 1'b0;
  logic [14:0] lim = '0;
  logic [3:0]  sel = '0;
  logic        bwait = 1'b0;
  logic        clr = 1'b0;
  logic        tmo_flag, tmo_pulse;

  int vectors = 0;
  int errors  = 0;
  int cycles  = 0;
  string cur_req = "R1";

  // model state
  int  m_pre = 0, m_cnt = 0;
  bit  m_fired = 0, m_flag = 0, m_pulse = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  i2c_stall_watchdog u_i2c_stall_watchdog (
    .clk(clk), .rst(rst), .wd_ctrl({en, lim}), .step_sel(sel),
    .bus_wait(bwait), .tmo_clr(clr),
    .tmo_flag(tmo_flag), .tmo_pulse(tmo_pulse)
  );

  // behavioural reference of R2..R11
  always @(posedge clk) begin
    bit tk, hit;
    int span;
    cycles++;
    hit = 0;
    if (rst) begin
      m_pre = 0; m_cnt = 0; m_fired = 0; m_flag = 0; m_pulse = 0;
    end else begin
      if (!(en && bwait)) begin
        m_pre = 0; m_cnt = 0; m_fired = 0;
      end else begin
        span = (1 << sel) - 1;
        tk = (m_pre >= span);
        m_pre = tk ? 0 : m_pre + 1;
        if (tk && !m_fired) begin
          m_cnt = m_cnt + 1;
          if (m_cnt >= int'(lim)) begin hit = 1; m_fired = 1; end
        end
      end
      m_pulse = hit;
      if (clr) m_flag = 0;
      else if (hit) m_flag = 1;
    end
  end

  always @(negedge clk) begin
    if (!rst) begin
      vectors++;
      if (tmo_pulse !== m_pulse) begin
        errors++;
        $display("FAIL %s cycle %0d tmo_pulse actual %0b expected %0b", cur_req, cycles, tmo_pulse, m_pulse);
      end
      if (tmo_flag !== m_flag) begin
        errors++;
        $display("FAIL %s cycle %0d tmo_flag actual %0b expected %0b", cur_req, cycles, tmo_flag, m_flag);
      end
    end
    if (cycles > WATCHDOG) begin
      errors++;
      $display("FAIL watchdog expired at cycle %0d actual hung expected done", cycles);
      finish_run();
    end
  end

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  endtask

  task automatic step(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(string req, string what, logic act, logic exp);
    vectors++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual %0b expected %0b", req, what, act, exp);
    end
  endtask

  task automatic quiesce();
    bwait = 0; en = 0; clr = 0;
    step(2);
  endtask

  initial begin
    step(3);
    rst = 0;
    step(1);
    cur_req = "R1";
    chk("R1", "flag after reset", tmo_flag, 1'b0);
    chk("R1", "pulse after reset", tmo_pulse, 1'b0);

    // R3 R4: L=3, n=2 -> fires after edge e0+11
    cur_req = "R4";
    en = 1; lim = 15'd3; sel = 4'd2; bwait = 1;
    step(11);
    chk("R4", "pulse before 12th edge", tmo_pulse, 1'b0);
    step(1);
    chk("R4", "pulse on 12th edge", tmo_pulse, 1'b1);
    chk("R9", "flag with pulse", tmo_flag, 1'b1);
    cur_req = "R6";
    step(1);
    chk("R6", "pulse one cycle only", tmo_pulse, 1'b0);
    step(60);
    chk("R6", "no refire in held stall", tmo_pulse, 1'b0);
    quiesce();
    cur_req = "R9";
    chk("R9", "flag sticky after stall", tmo_flag, 1'b1);
    clr = 1; step(1); clr = 0;
    chk("R9", "flag cleared", tmo_flag, 1'b0);

    // R5: zero limit
    cur_req = "R5";
    en = 1; lim = 15'd0; sel = 4'd0; bwait = 1;
    step(1);
    chk("R5", "zero limit n=0 first edge", tmo_pulse, 1'b1);
    quiesce();
    en = 1; sel = 4'd3; bwait = 1;
    step(7);
    chk("R5", "zero limit n=3 before step", tmo_pulse, 1'b0);
    step(1);
    chk("R5", "zero limit n=3 first step", tmo_pulse, 1'b1);
    quiesce();

    // R7: wait dip restarts
    cur_req = "R7";
    en = 1; lim = 15'd5; sel = 4'd0; bwait = 1;
    step(4);
    bwait = 0; step(1); bwait = 1;
    step(4);
    chk("R7", "no early fire after dip", tmo_pulse, 1'b0);
    step(1);
    chk("R7", "fire after full restart", tmo_pulse, 1'b1);
    quiesce();

    // R8: enable toggle keeps limit, restarts count
    cur_req = "R8";
    en = 1; lim = 15'd5; bwait = 1;
    step(3);
    en = 0; step(2);
    chk("R2", "disabled no pulse", tmo_pulse, 1'b0);
    en = 1;
    step(4);
    chk("R8", "no early fire after re-enable", tmo_pulse, 1'b0);
    step(1);
    chk("R8", "fire after re-enable restart", tmo_pulse, 1'b1);
    quiesce();

    // R10: clear and timeout on same edge
    cur_req = "R10";
    clr = 1; step(1); clr = 0;
    en = 1; lim = 15'd2; bwait = 1;
    step(1);
    clr = 1; step(1);
    chk("R10", "pulse on clear edge", tmo_pulse, 1'b1);
    chk("R10", "clear wins over timeout", tmo_flag, 1'b0);
    clr = 0; step(1);
    chk("R10", "flag still clear", tmo_flag, 1'b0);
    quiesce();

    // R11: lower limit below count
    cur_req = "R11";
    en = 1; lim = 15'd20; bwait = 1;
    step(10);
    chk("R11", "no fire before limit change", tmo_pulse, 1'b0);
    lim = 15'd4;
    step(1);
    chk("R11", "fire on next step after lowering", tmo_pulse, 1'b1);
    quiesce();

    // R2: waiting without enable, enable without waiting
    cur_req = "R2";
    en = 0; lim = 15'd0; bwait = 1;
    step(100);
    chk("R2", "waiting but disabled", tmo_pulse, 1'b0);
    en = 1; bwait = 0;
    step(100);
    chk("R2", "enabled but not waiting", tmo_pulse, 1'b0);
    quiesce();

    // R3: largest step size
    cur_req = "R3";
    en = 1; lim = 15'd1; sel = 4'd15; bwait = 1;
    step(32767);
    chk("R3", "n=15 before first step", tmo_pulse, 1'b0);
    step(1);
    chk("R3", "n=15 first step fires", tmo_pulse, 1'b1);
    quiesce();

    finish_run();
  end
endmodule